// File: doc/BRIEF.md
# Two-Phase Hardwired Instruction Controller

This block sequences a small accumulator machine through fixed time slots. Each instruction takes two machine cycles, a fetch phase and an execute phase, and each phase is four beats long. A beat counter and a phase flag are combined, through fixed AND-OR terms, with the one-hot output of an opcode decoder. The result is a set of micro-operation strobes that move words between the program counter, the memory address register, the memory data register and the instruction register. The same strobes start memory reads and writes and tell an external ALU what to do with the accumulator.

Main memory sits outside the block. It is a read/write port whose read data is presented for the address on `memAddr` and is captured at the end of the read beat. A write happens at the clock edge that ends the write beat. The accumulator and the ALU are also external. The block reads the accumulator value, uses it for the zero test and as store data, and drives an ALU enable and an operation code. The instruction word is eight bits: the opcode is in bits [7:5] and the address field in bits [4:0].

Top module: `acu_top`

## Requirements
- R1: While reset is held and at the first sample after its release, the block is in the fetch phase, beat 0 (first beat), with `pcOut` = 0 and `memRead`, `memWrite` and `aluGo` all low.
- R2: The beat counter advances by one every clock, 0,1,2,3. The phase flag `exePhase` toggles after beat 3, so fetch and execute alternate with four beats each.
- R3: Fetch is identical for every opcode. In beat 0 the PC is copied to the address register. In beat 1 memory is read at that PC. After beat 2 `pcOut` has increased by 1, and after beat 3 the fetched word is the instruction.
- R4: `memRead` equals beat1 AND (fetch OR (execute AND opcode is load-acc 3'd1 or add 3'd5)). In execute beat 1, `memAddr` is the instruction's address field.
- R5: Store 3'd2 raises `memWrite` only in execute beat 2. During that beat `memAddr` is the address field and `memWdata` is the accumulator value sampled in execute beat 1.
- R6: `aluGo` is high only in execute beat 2, for load 3'd1 (`aluOp` 00), add 3'd5 (01), complement 3'd6 (10) and shift-left 3'd0 (11). `aluOperand` carries the word read in execute beat 1.
- R7: Jump 3'd3 sets the PC to the address field. Jump-if-zero 3'd4 does so only when `accIn` is zero; otherwise the PC keeps its incremented value.
- R8: Opcode 3'd7 raises no read, write or ALU strobe in execute and leaves the PC at its incremented value.
- R9: The PC is 5 bits wide and increments from 31 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| memAddr | output | 5 | Memory address (address register) |
| memRead | output | 1 | Memory read strobe; data is captured at the end of this beat |
| memWrite | output | 1 | Memory write strobe; the write happens at the closing edge |
| memWdata | output | 8 | Store data (data register) |
| memRdata | input | 8 | Read data for `memAddr` |
| accIn | input | 8 | Current accumulator value |
| aluGo | output | 1 | Accumulator update enable |
| aluOp | output | 2 | 00 load, 01 add, 10 complement, 11 shift left |
| aluOperand | output | 8 | Memory operand for the ALU |
| pcOut | output | 5 | Program counter |
| beatOut | output | 2 | Current beat, 0..3 |
| exePhase | output | 1 | 0 fetch, 1 execute |

## Verification
The bench builds the block with its default widths: a 3-bit opcode, a 5-bit address and an 8-bit word. With these widths the whole 32-word program space fits in a short directed program, so the PC wrap from 31 to 0 is reached within a few instructions. The program visits every opcode, including the unused one. It runs jump-if-zero once with a nonzero accumulator and once with a zero accumulator. At each beat the bench compares the strobes and addresses with values it derives from the instruction word and from its own memory and accumulator models.

// File: rtl/acu_pkg.sv
package acu_pkg;
  parameter int OP_W   = 3;
  parameter int ADDR_W = 5;
  parameter int WORD_W = OP_W + ADDR_W;
  parameter int BEAT_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_SHL = 3'd0, OP_LDA = 3'd1, OP_STA = 3'd2, OP_JMP = 3'd3,
    OP_JZ  = 3'd4, OP_ADD = 3'd5, OP_COM = 3'd6, OP_NOP = 3'd7
  } opcode_e;

  typedef enum logic [1:0] {
    ALU_LOAD = 2'b00, ALU_ADD = 2'b01, ALU_INV = 2'b10, ALU_SHL = 2'b11
  } aluop_e;

  typedef struct packed {
    logic   marFromPc;
    logic   marFromAddr;
    logic   mdrFromMem;
    logic   mdrFromAcc;
    logic   pcInc;
    logic   pcFromAddr;
    logic   irLoad;
    logic   memRd;
    logic   memWr;
    logic   aluGo;
    aluop_e aluOp;
  } strobes_t;
endpackage

// File: rtl/acu_control.sv
module acu_control
  import acu_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int BW  = BEAT_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [OPW-1:0] opcode,
  input  logic           accZero,
  output logic [BW-1:0]  beat,
  output logic           inExe,
  output strobes_t       stb
);
  localparam int NUM_OPS   = 1 << OPW;
  localparam logic [BW-1:0] LAST_BEAT = BW'((1 << BW) - 1);

  logic [NUM_OPS-1:0] opHot;
  logic [3:0] c;
  logic fe, ex;
  logic isShl, isLda, isSta, isJmp, isJz, isAdd, isCom, memOperand;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beat  <= '0;
      inExe <= 1'b0;
    end else begin
      beat <= beat + 1'b1;
      if (beat == LAST_BEAT) inExe <= ~inExe;
    end
  end

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_dec
    assign opHot[g] = (opcode == OPW'(g));
  end

  for (genvar b = 0; b < 4; b++) begin : g_beat
    assign c[b] = (beat == BW'(b));
  end

  assign fe = ~inExe;
  assign ex = inExe;
  assign isShl = opHot[OP_SHL];
  assign isLda = opHot[OP_LDA];
  assign isSta = opHot[OP_STA];
  assign isJmp = opHot[OP_JMP];
  assign isJz  = opHot[OP_JZ];
  assign isAdd = opHot[OP_ADD];
  assign isCom = opHot[OP_COM];
  assign memOperand = isLda | isAdd;

  always_comb begin
    stb.marFromPc   = fe & c[0];
    stb.memRd       = c[1] & (fe | (ex & memOperand));
    stb.mdrFromMem  = stb.memRd;
    stb.pcInc       = fe & c[2];
    stb.irLoad      = fe & c[3];
    stb.marFromAddr = ex & ((c[0] & memOperand) | (c[1] & isSta));
    stb.mdrFromAcc  = ex & c[1] & isSta;
    stb.memWr       = ex & c[2] & isSta;
    stb.pcFromAddr  = ex & c[2] & (isJmp | (isJz & accZero));
    stb.aluGo       = ex & c[2] & (isLda | isAdd | isCom | isShl);
    stb.aluOp       = isAdd ? ALU_ADD : isCom ? ALU_INV : isShl ? ALU_SHL : ALU_LOAD;
  end
endmodule

// File: rtl/acu_datapath.sv
module acu_datapath
  import acu_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int AW  = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [OPW+AW-1:0] memRdata,
  input  logic [OPW+AW-1:0] accIn,
  output logic [OPW-1:0]    opcode,
  output logic [AW-1:0]     pc,
  output logic [AW-1:0]     mar,
  output logic [OPW+AW-1:0] mdr
);
  localparam int WW = OPW + AW;

  logic [WW-1:0] ir;
  logic [AW-1:0] addrField;

  assign opcode    = ir[WW-1 -: OPW];
  assign addrField = ir[AW-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
    end else begin
      if (stb.marFromPc)        mar <= pc;
      else if (stb.marFromAddr) mar <= addrField;
      if (stb.mdrFromMem)       mdr <= memRdata;
      else if (stb.mdrFromAcc)  mdr <= accIn;
      if (stb.pcInc)            pc  <= pc + 1'b1;
      else if (stb.pcFromAddr)  pc  <= addrField;
      if (stb.irLoad)           ir  <= mdr;
    end
  end
endmodule

// File: rtl/acu_top.sv
module acu_top
  import acu_pkg::*;
#(
  parameter int OPW = OP_W,
  parameter int AW  = ADDR_W,
  parameter int BW  = BEAT_W
) (
  input  logic              clk,
  input  logic              rstN,
  output logic [AW-1:0]     memAddr,
  output logic              memRead,
  output logic              memWrite,
  output logic [OPW+AW-1:0] memWdata,
  input  logic [OPW+AW-1:0] memRdata,
  input  logic [OPW+AW-1:0] accIn,
  output logic              aluGo,
  output logic [1:0]        aluOp,
  output logic [OPW+AW-1:0] aluOperand,
  output logic [AW-1:0]     pcOut,
  output logic [BW-1:0]     beatOut,
  output logic              exePhase
);
  strobes_t       stb;
  logic [OPW-1:0] opcode;
  logic [OPW+AW-1:0] mdr;

  acu_control #(.OPW(OPW), .BW(BW)) i_ctrl (
    .clk(clk), .rstN(rstN), .opcode(opcode), .accZero(accIn == '0),
    .beat(beatOut), .inExe(exePhase), .stb(stb)
  );

  acu_datapath #(.OPW(OPW), .AW(AW)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .memRdata(memRdata), .accIn(accIn),
    .opcode(opcode), .pc(pcOut), .mar(memAddr), .mdr(mdr)
  );

  assign memRead    = stb.memRd;
  assign memWrite   = stb.memWr;
  assign memWdata   = mdr;
  assign aluOperand = mdr;
  assign aluGo      = stb.aluGo;
  assign aluOp      = stb.aluOp;
endmodule

// File: rtl/acu_checker.sv
module acu_checker #(
  parameter int AW = 5,
  parameter int BW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic [BW-1:0] beatOut,
  input logic          exePhase,
  input logic          memRead,
  input logic          memWrite,
  input logic          aluGo,
  input logic [AW-1:0] pcOut
);
  a_r2_beat_steps: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> beatOut == BW'($past(beatOut) + 1'b1));
  a_r2_phase_flips: assert property (@(posedge clk) disable iff (!rstN)
    (beatOut == BW'((1 << BW) - 1)) |=> exePhase != $past(exePhase));
  a_r3_pc_increment: assert property (@(posedge clk) disable iff (!rstN)
    (!exePhase && beatOut == BW'(2)) |=> pcOut == AW'($past(pcOut) + 1'b1));
  a_r4_read_beat_one: assert property (@(posedge clk) disable iff (!rstN)
    memRead |-> beatOut == BW'(1));
  a_r5_write_exe_beat_two: assert property (@(posedge clk) disable iff (!rstN)
    memWrite |-> (exePhase && beatOut == BW'(2) && !memRead));
  a_r6_alu_exe_beat_two: assert property (@(posedge clk) disable iff (!rstN)
    aluGo |-> (exePhase && beatOut == BW'(2)));
endmodule

bind acu_top acu_checker #(.AW(AW), .BW(BW)) i_chk (
  .clk(clk), .rstN(rstN), .beatOut(beatOut), .exePhase(exePhase),
  .memRead(memRead), .memWrite(memWrite), .aluGo(aluGo), .pcOut(pcOut)
);

// File: tb/test_acu_top.sv
module test_acu_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] memAddr;
  logic       memRead, memWrite, aluGo, exePhase;
  logic [7:0] memWdata, memRdata, aluOperand;
  logic [1:0] aluOp, beatOut;
  logic [4:0] pcOut;
  logic [7:0] acc = 8'h00;
  logic [7:0] mem [32];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acu_top i_acu_top (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memRead(memRead),
    .memWrite(memWrite), .memWdata(memWdata), .memRdata(memRdata),
    .accIn(acc), .aluGo(aluGo), .aluOp(aluOp), .aluOperand(aluOperand),
    .pcOut(pcOut), .beatOut(beatOut), .exePhase(exePhase)
  );

  assign memRdata = mem[memAddr];

  always @(posedge clk) begin
    if (memWrite) mem[memAddr] <= memWdata;
    if (aluGo) begin
      case (aluOp)
        2'b00: acc <= aluOperand;
        2'b01: acc <= acc + aluOperand;
        2'b10: acc <= ~acc;
        default: acc <= {acc[6:0], 1'b0};
      endcase
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic testReset();
    check(exePhase == 1'b0 && beatOut == 2'd0, "R1 phase/beat", {exePhase, beatOut}, 0);
    check(pcOut == 5'd0, "R1 pc", pcOut, 0);
    check(!memRead && !memWrite && !aluGo, "R1 strobes", {memRead, memWrite, aluGo}, 0);
  endtask

  // Called just after a negedge in fetch beat 0; returns at fetch beat 0 of the next instruction.
  task automatic runInstr(input string name, input bit expRd, input bit expWr,
                          input bit expAlu, input logic [1:0] expOp,
                          input logic [4:0] expNextPc, input logic [7:0] expAcc);
    logic [4:0] startPc = pcOut;
    logic [7:0] word = mem[startPc];
    logic [4:0] addr = word[4:0];
    int reads = 0;
    logic [7:0] accAtB1 = 8'h00;
    for (int b = 0; b < 8; b++) begin
      check(beatOut == 2'(b % 4) && exePhase == (b >= 4), {"R2 ", name},
            {exePhase, beatOut}, {b >= 4, 2'(b % 4)});
      if (memRead) reads++;
      if (b == 1) check(memRead && memAddr == startPc, {"R3 fetch read ", name}, memAddr, startPc);
      if (b == 3) check(pcOut == 5'(startPc + 1), {"R3 pc+1 ", name}, pcOut, 5'(startPc + 1));
      if (b == 5) begin
        check(memRead == expRd, {"R4 exe read ", name}, memRead, expRd);
        if (expRd) check(memAddr == addr, {"R4 exe addr ", name}, memAddr, addr);
        accAtB1 = acc;
      end
      if (b == 6) begin
        check(memWrite == expWr, {"R5 write ", name}, memWrite, expWr);
        if (expWr) check(memAddr == addr && memWdata == accAtB1, {"R5 data ", name},
                         {memAddr, memWdata}, {addr, accAtB1});
        check(aluGo == expAlu, {"R6 aluGo ", name}, aluGo, expAlu);
        if (expAlu) check(aluOp == expOp, {"R6 aluOp ", name}, aluOp, expOp);
        if (expRd) check(aluOperand == mem[addr], {"R6 operand ", name}, aluOperand, mem[addr]);
      end
      if (b != 6) check(!memWrite && !aluGo, {"R5 R6 quiet ", name}, {memWrite, aluGo}, 0);
      @(negedge clk);
    end
    check(reads == 1 + int'(expRd), {"R4 read count ", name}, reads, 1 + int'(expRd));
    check(pcOut == expNextPc, {"R7 R8 R9 next pc ", name}, pcOut, expNextPc);
    check(acc == expAcc, {"R6 acc ", name}, acc, expAcc);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    mem[0]  = 8'h34; // load 20
    mem[1]  = 8'hB5; // add 21
    mem[2]  = 8'h56; // store 22
    mem[3]  = 8'hC0; // complement
    mem[4]  = 8'h00; // shift left
    mem[5]  = 8'h89; // jz 9 (not taken)
    mem[6]  = 8'h68; // jmp 8
    mem[8]  = 8'h37; // load 23 (zero)
    mem[9]  = 8'h8C; // jz 12 (taken)
    mem[12] = 8'hE0; // unused opcode
    mem[13] = 8'h7F; // jmp 31
    mem[31] = 8'hC0; // complement, pc wraps
    mem[20] = 8'h35;
    mem[21] = 8'h0B;
    mem[23] = 8'h00;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    // sync: reset is released mid-flight; realign to fetch beat 0
    rstN = 1'b0;
    @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(beatOut == 2'd1 && !exePhase, "R2 first step", beatOut, 1);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    // reset sampled at this negedge's next posedge was low; now state is fetch beat 0
    testReset();
    runInstr("LDA", 1, 0, 1, 2'b00, 5'd1,  8'h35);
    runInstr("ADD", 1, 0, 1, 2'b01, 5'd2,  8'h40);
    runInstr("STA", 0, 1, 0, 2'b00, 5'd3,  8'h40);
    check(mem[22] == 8'h40, "R5 stored word", mem[22], 8'h40);
    runInstr("COM", 0, 0, 1, 2'b10, 5'd4,  8'hBF);
    runInstr("SHL", 0, 0, 1, 2'b11, 5'd5,  8'h7E);
    runInstr("JZ nonzero", 0, 0, 0, 2'b00, 5'd6, 8'h7E);
    runInstr("JMP", 0, 0, 0, 2'b00, 5'd8,  8'h7E);
    runInstr("LDA zero", 1, 0, 1, 2'b00, 5'd9, 8'h00);
    runInstr("JZ zero", 0, 0, 0, 2'b00, 5'd12, 8'h00);
    runInstr("unused op R8", 0, 0, 0, 2'b00, 5'd13, 8'h00);
    runInstr("JMP 31", 0, 0, 0, 2'b00, 5'd31, 8'h00);
    runInstr("COM wrap R9", 0, 0, 1, 2'b10, 5'd0, 8'hFF);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule